// File: doc/BRIEF.md
# GPU L2 Line Coherence Controller

This block holds the coherence state of one line in a shared second-level GPU cache. That cache sits between many first-level caches and a directory on the memory side. The controller receives four kinds of event. Core requests are a block read, a byte-masked write or an atomic. Invalidating probes arrive from the directory. Memory responses are either returning data or a write acknowledge. A replacement order arrives when this line is chosen as a victim. For each event the controller chooses the next line state and the messages to emit in that cycle. The messages are data or an acknowledge to cores, a read, write or atomic request to memory, a probe reply and an unblock. When a core request cannot be taken in the current cycle, the controller raises `req_retry`, and the requester must present the same request again later.

The parameter `WB` selects the write policy. With `WB=1` the line absorbs writes and becomes dirty. With `WB=0` every write is passed through to memory. The tag and data arrays are outside this block, as are the network and the replacement policy. The block only keeps the line's bytes, its dirty byte mask, the set of readers waiting for a fill and the count of outstanding atomics. All outputs are combinational from the registered state and the inputs of the current cycle. Every output is zero when it is not asserted.

Top module: `gpu_l2_line_ctrl`

## Requirements
- R1: After reset the line is invalid (state code 0), the dirty mask is clear and no message output is active. The state codes are I=0, V=1, M=2, W=3, IV=4, WI=5 and A=6.
- R2: A read (op 0) in V or M is answered at once on `core_data` with the line's bytes, addressed one-hot to the requester, with `mru` set and no memory request.
- R3: A read in I issues `mem_rd` carrying the requester and moves to IV. Further reads in IV are accepted without a new memory request. A data response (`rsp_kind`=0) in IV stores the bytes, clears the dirty mask, sends them to every collected reader, pulses `unblock` and moves to V.
- R4: A read or an atomic (op 2) in W, or an atomic in M, issues a line write-back and moves to WI. The write-back is `mem_wr` with `mem_self`=1, the line bytes and the dirty mask. The request is retried.
- R5: An atomic in I or V clears the dirty mask, issues `mem_atom` with the requester, mask and operand, and moves to A with one outstanding atomic. In A, further atomics are forwarded and counted up to `ATOM_MAX`. Any atomic beyond that is retried.
- R6: In WI every request is retried. In A, reads and writes (op 1) are retried. In IV, writes and atomics are retried.
- R7: A data response in A is forwarded to the core named by `rsp_dst` and reduces the outstanding count. The response that retires the last atomic moves the line to I.
- R8: With `WB=0`, a write in V merges only the masked bytes into the line and forwards the write. A write in I is forwarded without allocating. States M and W never occur.
- R9: With `WB=1`, a write is acknowledged to the requester, merges its masked bytes and ORs its mask into the dirty mask. The state moves I to W, V or M to M, and W stays W. A write in I while `room` is low is retried and raises `need_victim`.
- R10: A replacement of an M or W line writes the line back with its dirty mask and moves to WI. A replacement of a V line moves to I. A replacement leaves I and the transient states unchanged.
- R11: A probe is always answered by `prb_ack`. V goes to I and M goes to W. W, I and the transient states keep their state.
- R12: A write acknowledge (`rsp_kind`=1) in WI moves to I. In I, V, IV or A it is relayed on `core_ack` to `rsp_dst`. A forwarded core write carries the writer's identifier on `mem_src` with `mem_self`=0.
- R13: One event is served per cycle, in the priority response, probe, replacement, request. A request that is not served in a cycle sees `req_retry` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | 0 read, 1 write, 2 atomic |
| req_src | input | SRC_W | Requesting core |
| req_mask | input | BYTES | Byte enables of a write or atomic |
| req_data | input | 8*BYTES | Write data or atomic operand |
| room | input | 1 | Line present or a free way exists |
| prb_valid | input | 1 | Invalidating probe |
| repl_valid | input | 1 | Line chosen as victim |
| rsp_valid | input | 1 | Memory response present |
| rsp_kind | input | 1 | 0 data, 1 write acknowledge |
| rsp_dst | input | SRC_W | Core the response belongs to |
| rsp_data | input | 8*BYTES | Response bytes |
| req_retry | output | 1 | Request not taken this cycle |
| need_victim | output | 1 | Write needs a way freed first |
| core_data_v | output | 1 | Data message to cores |
| core_ack_v | output | 1 | Write acknowledge to a core |
| core_dst | output | NCORE | Destination cores, one bit each |
| core_data | output | 8*BYTES | Bytes sent to cores |
| mem_rd | output | 1 | Read request to memory |
| mem_wr | output | 1 | Write request to memory |
| mem_atom | output | 1 | Atomic request to memory |
| mem_self | output | 1 | Write is this line's own write-back |
| mem_src | output | SRC_W | Originating core of a forwarded request |
| mem_mask | output | BYTES | Byte mask of the memory request |
| mem_data | output | 8*BYTES | Bytes of the memory request |
| prb_ack | output | 1 | Probe reply without data or hit |
| unblock | output | 1 | Fill completed, directory may proceed |
| mru | output | 1 | Mark line most recently used |
| state_o | output | 3 | Current line state code |
| dirty_o | output | BYTES | Current dirty byte mask |

## Verification
Some rules are checked on every cycle. All requests are held off while a write-back is pending. A probe is always answered. A probe demotes M to W. No dirty bytes remain while atomics are in flight. At most one memory request is issued per cycle. A fill in IV ends in V. A read hit stays local. The write-through variant never reaches an owned state. Other behaviour can only be shown by the bench's scenarios, because it depends on history. That covers merging reader sets while a fill is pending, ORing dirty masks across writes, saturating the atomic count, replaying a request after its write-back is acknowledged, and the byte-level merge of masked writes.

// File: rtl/gpu_l2_line_ctrl.sv
module gpu_l2_line_ctrl #(
  parameter int NCORE    = 4,
  parameter int BYTES    = 4,
  parameter int ATOM_MAX = 7,
  parameter bit WB       = 1'b1,
  localparam int SRC_W   = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int DW      = 8 * BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [SRC_W-1:0] req_src,
  input  logic [BYTES-1:0] req_mask,
  input  logic [DW-1:0]    req_data,
  input  logic             room,
  input  logic             prb_valid,
  input  logic             repl_valid,
  input  logic             rsp_valid,
  input  logic             rsp_kind,
  input  logic [SRC_W-1:0] rsp_dst,
  input  logic [DW-1:0]    rsp_data,
  output logic             req_retry,
  output logic             need_victim,
  output logic             core_data_v,
  output logic             core_ack_v,
  output logic [NCORE-1:0] core_dst,
  output logic [DW-1:0]    core_data,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             mem_atom,
  output logic             mem_self,
  output logic [SRC_W-1:0] mem_src,
  output logic [BYTES-1:0] mem_mask,
  output logic [DW-1:0]    mem_data,
  output logic             prb_ack,
  output logic             unblock,
  output logic             mru,
  output logic [2:0]       state_o,
  output logic [BYTES-1:0] dirty_o
);
  localparam int CW = $clog2(ATOM_MAX + 1);
  localparam logic [2:0] S_I = 3'd0, S_V = 3'd1, S_M = 3'd2, S_W = 3'd3,
                         S_IV = 3'd4, S_WI = 3'd5, S_A = 3'd6;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_AT = 2'd2;

  logic [2:0]       st, st_n;
  logic [DW-1:0]    line_q, line_n, merged;
  logic [BYTES-1:0] mask_q, mask_n;
  logic [NCORE-1:0] dest_q, dest_n, src_oh, rsp_oh;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             wb_start, fwd;

  assign src_oh  = NCORE'(1) << req_src;
  assign rsp_oh  = NCORE'(1) << rsp_dst;
  assign state_o = st;
  assign dirty_o = mask_q;

  always_comb begin
    for (int b = 0; b < BYTES; b++)
      merged[b*8 +: 8] = req_mask[b] ? req_data[b*8 +: 8] : line_q[b*8 +: 8];
  end

  always_comb begin
    st_n = st; line_n = line_q; mask_n = mask_q; dest_n = dest_q; cnt_n = cnt_q;
    req_retry = req_valid; need_victim = 1'b0;
    core_data_v = 1'b0; core_ack_v = 1'b0; core_dst = '0; core_data = '0;
    mem_rd = 1'b0; mem_wr = 1'b0; mem_atom = 1'b0; mem_self = 1'b0;
    mem_src = '0; mem_mask = '0; mem_data = '0;
    prb_ack = 1'b0; unblock = 1'b0; mru = 1'b0;
    wb_start = 1'b0; fwd = 1'b0;
    if (rsp_valid) begin
      if (!rsp_kind) begin
        if (st == S_IV) begin
          line_n = rsp_data; mask_n = '0; dest_n = '0; st_n = S_V;
          core_data_v = 1'b1; core_dst = dest_q; core_data = rsp_data; unblock = 1'b1;
        end else if (st == S_A) begin
          core_data_v = 1'b1; core_dst = rsp_oh; core_data = rsp_data;
          cnt_n = cnt_q - CW'(1);
          if (cnt_q == CW'(1)) st_n = S_I;
        end
      end else if (st == S_WI) begin
        st_n = S_I;
      end else if (st == S_I || st == S_V || st == S_IV || st == S_A) begin
        core_ack_v = 1'b1; core_dst = rsp_oh;
      end
    end else if (prb_valid) begin
      prb_ack = 1'b1;
      if (st == S_V) st_n = S_I;
      else if (st == S_M) st_n = S_W;
    end else if (repl_valid) begin
      if (st == S_M || st == S_W) wb_start = 1'b1;
      else if (st == S_V) st_n = S_I;
    end else if (req_valid) begin
      case (req_op)
        OP_RD: case (st)
          S_M, S_V: begin
            req_retry = 1'b0; mru = 1'b1;
            core_data_v = 1'b1; core_dst = src_oh; core_data = line_q;
          end
          S_I: begin
            req_retry = 1'b0; mem_rd = 1'b1; mem_src = req_src;
            dest_n = src_oh; st_n = S_IV;
          end
          S_IV: begin req_retry = 1'b0; dest_n = dest_q | src_oh; end
          S_W: wb_start = 1'b1;
          default: ;
        endcase
        OP_AT: case (st)
          S_I, S_V: begin fwd = 1'b1; mask_n = '0; cnt_n = CW'(1); st_n = S_A; end
          S_A: if (cnt_q != CW'(ATOM_MAX)) begin fwd = 1'b1; cnt_n = cnt_q + CW'(1); end
          S_M, S_W: wb_start = 1'b1;
          default: ;
        endcase
        OP_WR: if (WB) begin
          if ((st == S_I && room) || st == S_V || st == S_M || st == S_W) begin
            req_retry = 1'b0; mru = 1'b1;
            core_ack_v = 1'b1; core_dst = src_oh; line_n = merged;
            mask_n = (st == S_I) ? req_mask : (mask_q | req_mask);
            st_n = (st == S_W || st == S_I) ? S_W : S_M;
          end else if (st == S_I) begin
            need_victim = 1'b1;
          end
        end else begin
          if (st == S_I || st == S_V) begin
            req_retry = 1'b0; mem_wr = 1'b1; mem_src = req_src;
            mem_mask = req_mask; mem_data = req_data;
          end
          if (st == S_V) begin line_n = merged; mask_n = mask_q | req_mask; mru = 1'b1; end
        end
        default: ;
      endcase
      if (fwd) begin
        req_retry = 1'b0; mem_atom = 1'b1; mem_src = req_src;
        mem_mask = req_mask; mem_data = req_data;
      end
    end
    if (wb_start) begin
      mem_wr = 1'b1; mem_self = 1'b1; mem_mask = mask_q; mem_data = line_q;
      mask_n = '0; st_n = S_WI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_I; line_q <= '0; mask_q <= '0; dest_q <= '0; cnt_q <= '0;
    end else begin
      st <= st_n; line_q <= line_n; mask_q <= mask_n; dest_q <= dest_n; cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/gpu_l2_line_chk.sv
module gpu_l2_line_chk #(
  parameter int BYTES = 4,
  parameter bit WB    = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic             prb_valid,
  input logic             repl_valid,
  input logic             rsp_valid,
  input logic             rsp_kind,
  input logic             req_retry,
  input logic             core_data_v,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             mem_atom,
  input logic             prb_ack,
  input logic [2:0]       state_o,
  input logic [BYTES-1:0] dirty_o
);
  a_r6_wi_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && req_valid) |-> req_retry);

  a_r11_probe_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && !rsp_valid) |-> prb_ack);

  a_r11_probe_demotes: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && prb_valid && !rsp_valid) |=> state_o == 3'd3);

  a_r5_atomic_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |-> dirty_o == '0);

  a_r13_one_mem_req: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr, mem_atom}) <= 1);

  a_r2_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && (state_o == 3'd1 || state_o == 3'd2) &&
     !rsp_valid && !prb_valid && !repl_valid) |-> (core_data_v && !mem_rd && !req_retry));

  a_r3_fill_ends_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && rsp_valid && !rsp_kind) |=> state_o == 3'd1);

  if (!WB) begin : g_wt
    a_r8_never_owned: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 3'd2 && state_o != 3'd3);
  end
endmodule

bind gpu_l2_line_ctrl gpu_l2_line_chk #(.BYTES(BYTES), .WB(WB)) chk_i (.*);

// File: tb/gpu_l2_line_ctrl_tb_top.sv
module gpu_l2_line_ctrl_tb_top;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic retry, victim, cdv, cav;
    logic [3:0] dst;
    logic [31:0] cdata;
    logic rd, wr, at, self;
    logic [1:0] src;
    logic [3:0] mmask;
    logic [31:0] mdata;
    logic pack, unb, mru;
    logic [2:0] st;
    logic [3:0] dirty;
  } outs_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, room = 1, prb_valid = 0, repl_valid = 0, rsp_valid = 0, rsp_kind = 0;
  logic [1:0] req_op = 0, req_src = 0, rsp_dst = 0;
  logic [3:0] req_mask = 0;
  logic [31:0] req_data = 0, rsp_data = 0;

  outs_t act [2];
  outs_t ex  [2];

  logic w_retry, w_victim, w_cdv, w_cav, w_rd, w_wr, w_at, w_self, w_pack, w_unb, w_mru;
  logic [3:0] w_dst, w_mmask, w_dirty; logic [31:0] w_cdata, w_mdata; logic [1:0] w_src; logic [2:0] w_st;
  logic t_retry, t_victim, t_cdv, t_cav, t_rd, t_wr, t_at, t_self, t_pack, t_unb, t_mru;
  logic [3:0] t_dst, t_mmask, t_dirty; logic [31:0] t_cdata, t_mdata; logic [1:0] t_src; logic [2:0] t_st;

  always #(CLK_P/2) clk = ~clk;

  gpu_l2_line_ctrl #(.WB(1'b1)) dut_i (
    .clk, .rst_n, .req_valid, .req_op, .req_src, .req_mask, .req_data, .room,
    .prb_valid, .repl_valid, .rsp_valid, .rsp_kind, .rsp_dst, .rsp_data,
    .req_retry(w_retry), .need_victim(w_victim), .core_data_v(w_cdv), .core_ack_v(w_cav),
    .core_dst(w_dst), .core_data(w_cdata), .mem_rd(w_rd), .mem_wr(w_wr), .mem_atom(w_at),
    .mem_self(w_self), .mem_src(w_src), .mem_mask(w_mmask), .mem_data(w_mdata),
    .prb_ack(w_pack), .unblock(w_unb), .mru(w_mru), .state_o(w_st), .dirty_o(w_dirty));

  gpu_l2_line_ctrl #(.WB(1'b0)) dut_wt_i (
    .clk, .rst_n, .req_valid, .req_op, .req_src, .req_mask, .req_data, .room,
    .prb_valid, .repl_valid, .rsp_valid, .rsp_kind, .rsp_dst, .rsp_data,
    .req_retry(t_retry), .need_victim(t_victim), .core_data_v(t_cdv), .core_ack_v(t_cav),
    .core_dst(t_dst), .core_data(t_cdata), .mem_rd(t_rd), .mem_wr(t_wr), .mem_atom(t_at),
    .mem_self(t_self), .mem_src(t_src), .mem_mask(t_mmask), .mem_data(t_mdata),
    .prb_ack(t_pack), .unblock(t_unb), .mru(t_mru), .state_o(t_st), .dirty_o(t_dirty));

  assign act[0] = {w_retry, w_victim, w_cdv, w_cav, w_dst, w_cdata, w_rd, w_wr, w_at, w_self,
                   w_src, w_mmask, w_mdata, w_pack, w_unb, w_mru, w_st, w_dirty};
  assign act[1] = {t_retry, t_victim, t_cdv, t_cav, t_dst, t_cdata, t_rd, t_wr, t_at, t_self,
                   t_src, t_mmask, t_mdata, t_pack, t_unb, t_mru, t_st, t_dirty};

  // reference state: 0 = write-back instance, 1 = write-through instance
  int          m_st [2], n_st [2];
  logic [31:0] m_line [2], n_line [2];
  logic [3:0]  m_mask [2], n_mask [2], m_dest [2], n_dest [2];
  int          m_cnt [2], n_cnt [2];
  int checks = 0, fails = 0;
  bit finished = 0;

  localparam int I = 0, V = 1, M = 2, W = 3, IV = 4, WI = 5, A = 6;

  task automatic writeback(int k, ref outs_t e);
    e.wr = 1; e.self = 1; e.mmask = m_mask[k]; e.mdata = m_line[k];
    n_mask[k] = 0; n_st[k] = WI;
  endtask

  task automatic model(int k, bit wb);
    outs_t e = '0;
    logic [31:0] mrg;
    logic [3:0] soh = 4'b1 << req_src;
    logic [3:0] roh = 4'b1 << rsp_dst;
    int s = m_st[k];
    n_st[k] = s; n_line[k] = m_line[k]; n_mask[k] = m_mask[k];
    n_dest[k] = m_dest[k]; n_cnt[k] = m_cnt[k];
    for (int b = 0; b < 4; b++)
      mrg[b*8 +: 8] = req_mask[b] ? req_data[b*8 +: 8] : m_line[k][b*8 +: 8];
    e.retry = req_valid;
    if (rsp_valid) begin
      if (rsp_kind == 0) begin
        if (s == IV) begin
          e.cdv = 1; e.dst = m_dest[k]; e.cdata = rsp_data; e.unb = 1;
          n_line[k] = rsp_data; n_mask[k] = 0; n_dest[k] = 0; n_st[k] = V;
        end else if (s == A) begin
          e.cdv = 1; e.dst = roh; e.cdata = rsp_data; n_cnt[k] = m_cnt[k] - 1;
          if (m_cnt[k] == 1) n_st[k] = I;
        end
      end else begin
        if (s == WI) n_st[k] = I;
        else if (s == I || s == V || s == IV || s == A) begin e.cav = 1; e.dst = roh; end
      end
    end else if (prb_valid) begin
      e.pack = 1;
      if (s == V) n_st[k] = I;
      if (s == M) n_st[k] = W;
    end else if (repl_valid) begin
      if (s == M || s == W) writeback(k, e);
      else if (s == V) n_st[k] = I;
    end else if (req_valid) begin
      if (req_op == 0) begin
        if (s == M || s == V) begin e.retry = 0; e.mru = 1; e.cdv = 1; e.dst = soh; e.cdata = m_line[k]; end
        else if (s == I) begin e.retry = 0; e.rd = 1; e.src = req_src; n_dest[k] = soh; n_st[k] = IV; end
        else if (s == IV) begin e.retry = 0; n_dest[k] = m_dest[k] | soh; end
        else if (s == W) writeback(k, e);
      end else if (req_op == 2) begin
        if (s == I || s == V || (s == A && m_cnt[k] < 7)) begin
          e.retry = 0; e.at = 1; e.src = req_src; e.mmask = req_mask; e.mdata = req_data;
          if (s == A) n_cnt[k] = m_cnt[k] + 1;
          else begin n_cnt[k] = 1; n_mask[k] = 0; n_st[k] = A; end
        end else if (s == M || s == W) writeback(k, e);
      end else if (req_op == 1) begin
        if (wb) begin
          if (s == I && !room) e.victim = 1;
          else if (s == I || s == V || s == M || s == W) begin
            e.retry = 0; e.mru = 1; e.cav = 1; e.dst = soh; n_line[k] = mrg;
            n_mask[k] = (s == I) ? req_mask : (m_mask[k] | req_mask);
            n_st[k] = (s == I || s == W) ? W : M;
          end
        end else if (s == I || s == V) begin
          e.retry = 0; e.wr = 1; e.src = req_src; e.mmask = req_mask; e.mdata = req_data;
          if (s == V) begin n_line[k] = mrg; n_mask[k] = m_mask[k] | req_mask; e.mru = 1; end
        end
      end
    end
    e.st = 3'(s); e.dirty = m_mask[k];
    ex[k] = e;
  endtask

  task automatic cyc(string tag);
    #1;
    for (int k = 0; k < 2; k++) begin
      model(k, k == 0);
      checks++;
      if (act[k] !== ex[k]) begin
        fails++;
        $display("FAIL %s inst%0d: actual %h expected %h", tag, k, act[k], ex[k]);
      end
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      m_st[k] = n_st[k]; m_line[k] = n_line[k]; m_mask[k] = n_mask[k];
      m_dest[k] = n_dest[k]; m_cnt[k] = n_cnt[k];
    end
    @(negedge clk);
    req_valid = 0; prb_valid = 0; repl_valid = 0; rsp_valid = 0;
  endtask

  task automatic rq(logic [1:0] op, logic [1:0] src, logic [3:0] msk, logic [31:0] d, string tag);
    req_valid = 1; req_op = op; req_src = src; req_mask = msk; req_data = d; cyc(tag);
  endtask
  task automatic rs(logic kind, logic [1:0] dst, logic [31:0] d, string tag);
    rsp_valid = 1; rsp_kind = kind; rsp_dst = dst; rsp_data = d; cyc(tag);
  endtask
  task automatic pr(string tag); prb_valid = 1; cyc(tag); endtask
  task automatic rp(string tag); repl_valid = 1; cyc(tag); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_st[k] = I; m_line[k] = 0; m_mask[k] = 0; m_dest[k] = 0; m_cnt[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R1");
    rq(0, 0, 0, 0, "R3");             // miss, to IV
    rq(0, 2, 0, 0, "R3");             // extra reader merged
    rq(1, 1, 4'hF, 32'h1, "R6");      // write stalls in IV
    rq(2, 1, 4'hF, 32'h1, "R6");      // atomic stalls in IV
    rs(0, 0, 32'hA5A5_5A5A, "R3");    // fill to readers 0 and 2
    rq(0, 1, 0, 0, "R2");             // hit in V
    rq(1, 1, 4'b0011, 32'h1111_2222, "R9");   // WB: V->M ; WT: merge+forward R8
    rq(1, 3, 4'b1000, 32'h7700_0000, "R8");
    rq(0, 3, 0, 0, "R2");             // hit on merged bytes
    pr("R11");                        // WB M->W ; WT V->I
    rq(0, 0, 0, 0, "R4");             // WB: W writes back, WI ; WT: miss
    rq(0, 1, 0, 0, "R6");             // WB retried in WI
    rs(1, 1, 0, "R12");               // WB WI->I ; WT relays ack
    rs(0, 0, 32'hDEAD_BEEF, "R3");    // WT fill ; WB ignored in I
    rq(2, 2, 4'h3, 32'h55, "R5");     // atomic to A
    rq(2, 3, 4'hC, 32'h66, "R5");     // second atomic counted
    rq(0, 1, 0, 0, "R6");
    rq(1, 1, 4'h1, 32'h9, "R6");
    pr("R11");                        // probe in A keeps state
    rp("R10");                        // replacement in transient no effect
    rs(1, 2, 0, "R12");               // ack relayed in A
    rs(0, 2, 32'h0102_0304, "R7");
    rs(0, 3, 32'h0506_0708, "R7");    // last one, to I
    room = 0;
    rq(1, 0, 4'b0101, 32'h00AA_00BB, "R9");   // WB needs victim ; WT forward no alloc R8
    room = 1;
    rq(1, 0, 4'b0101, 32'h00AA_00BB, "R9");   // WB allocates to W
    rq(1, 2, 4'b0010, 32'h0000_CC00, "R9");   // mask ORs, stays W
    rs(1, 3, 0, "R12");               // ack in W ignored, in I relayed
    rp("R10");                        // WB W write-back to WI
    rq(1, 1, 4'h1, 32'h1, "R6");
    rs(1, 0, 0, "R12");               // WI->I
    for (int n = 0; n < 8; n++) rq(2, 2'(n), 4'hF, 32'(n), "R5");  // eighth retried
    for (int n = 0; n < 7; n++) rs(0, 2'(n), 32'(n + 100), "R7");
    rq(0, 1, 0, 0, "R3");
    rq(0, 1, 0, 0, "R13");            // merged reader
    rsp_valid = 1; rsp_kind = 0; rsp_dst = 0; rsp_data = 32'hCAFE_F00D;
    rq(0, 2, 0, 0, "R13");            // request loses to response
    prb_valid = 1; rq(0, 2, 0, 0, "R13");   // request loses to probe
    rq(0, 0, 0, 0, "R3");
    rs(0, 0, 32'h1234_5678, "R3");
    rp("R10");                        // V replaced to I
    rq(0, 0, 0, 0, "R3");
    rs(0, 0, 32'h8765_4321, "R3");
    rq(1, 1, 4'h2, 32'h0000_4400, "R9");    // WB V->M
    rq(2, 1, 4'h1, 32'h1, "R4");      // WB atomic in M writes back
    rs(1, 1, 0, "R12");
    rq(2, 1, 4'h1, 32'h1, "R5");      // replayed atomic
    rs(0, 1, 32'h42, "R7");
    pr("R11");
    cyc("R1");
    finished = 1;
    summary();
  end
endmodule